// File: doc/BRIEF.md
# Banked DMA Channel Control Register File

This block is the software-visible control and status register file for a multi-channel DMA engine. It holds the settings for every channel and every port, but its 32-bit register bus has only a small window. A channel-select register picks which channel's private register copy the banked window reaches. A port-select register does the same for the per-port control word. The engine's datapath reads the per-channel and per-port settings from flat output vectors. It sends one event pulse per channel when a descriptor completes. It receives a single combined interrupt line.

Each channel carries an on bit, a direction bit, a two-bit arbitration weight, a descriptor ring base and a descriptor count. A channel reset bit clears itself after a fixed number of cycles and can be polled. An interrupt status word is cleared by writing ones, and a per-channel enable word sits beside it. A global mask with one bit per channel gates each channel's contribution to the interrupt line. Reads and writes complete in a single cycle: writes take effect on the clock edge where `bus_we` is high, and `bus_rdata` is a combinational function of `bus_addr` and the stored state.

Top module: `dma_regbank`

## Requirements
- R1: After reset every register reads 0, every channel and port output is 0 and `irq` is 0.
- R2: Writing a channel number below NUM_CH to offset 0x18 makes offsets 0x1C, 0x20, 0x24, 0x28 and 0x2C read and write only that channel's copy; the other channels keep their values.
- R3: At offset 0x1C, bit 0 is channel on, bit 8 is transmit direction and bits 17:16 are the weight. These drive `ch_on`, `ch_tx` and `ch_weight` and read back at the same positions.
- R4: Writing 1 to bit 1 at 0x1C starts a channel reset. Bit 1 reads 1 for exactly RST_CYC (4) cycles after the write edge and then 0. The reset clears the on bit and the status word, ignores writes to the on bit while it runs, and leaves the base and count unchanged.
- R5: Offset 0x20 holds the 32-bit descriptor base and offset 0x24 the LEN_W-bit descriptor count. Both drive their outputs and read back.
- R6: A pulse on `ch_event[n]` sets status bit 3 (descriptor complete) of channel n, read at 0x28. Writing a one to a status bit clears it, so writing 0x7E clears all of bits 6:1.
- R7: Interrupt enables sit at 0x2C bits 6:1. `irq` is high when, for some channel n, status AND enable is nonzero and bit n of the global mask at 0xF4 (NUM_CH bits) is set.
- R8: Writing 1 to bit 0 at 0x10 starts the channel reset of every channel. Bit 0 at 0x10 reads 1 while any channel reset runs.
- R9: At offset 0x14, bit 31 (polling on) and bit 6 (divide-by-4 poll clock) are stored, drive `poll_en` and `poll_div4`, and read back. The other bits read 0.
- R10: Writing a port number below NUM_PORT to 0x40 banks 0x44 to that port. There, bits 11:8 are the byte-swap field, bit 6 is packet drop, bits 5:4 are burst A and bits 3:2 are burst B. The other bits read 0.
- R11: Reads of 0x18, 0x40 and unmapped offsets return 0. A select value of NUM_CH or more (NUM_PORT or more for ports) makes banked reads return 0 and banked writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| ch_event | input | NUM_CH | Descriptor-complete pulse per channel |
| ch_on | output | NUM_CH | Channel enabled |
| ch_tx | output | NUM_CH | Channel direction is transmit |
| ch_weight | output | 2*NUM_CH | Arbitration weight per channel |
| ch_base | output | 32*NUM_CH | Descriptor ring base per channel |
| ch_len | output | LEN_W*NUM_CH | Descriptor count per channel |
| ch_busy | output | NUM_CH | Channel reset in progress |
| poll_en | output | 1 | Descriptor polling enabled |
| poll_div4 | output | 1 | Poll clock divided by four |
| port_swap | output | 4*NUM_PORT | Byte-swap field per port |
| port_drop | output | NUM_PORT | Packet drop enable per port |
| port_burst_a | output | 2*NUM_PORT | Burst field A per port |
| port_burst_b | output | 2*NUM_PORT | Burst field B per port |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check these properties:
- A resetting channel is never on, and its reset lasts beyond one cycle.
- An event on an idle channel sets its done bit.
- A write-one clear of that bit takes hold when no event competes with it.
- `irq` only rises under a set global mask bit.
- An out-of-range channel select makes banked reads return zero and leaves the channel outputs untouched.

The bench scenarios cover the rest:
- the exact four-cycle length of a reset;
- preservation of base and count across a reset;
- isolation between banked copies;
- the field packing of the polling and port words;
- the full path from event to interrupt through both enable levels.

// File: rtl/dma_regbank_pkg.sv
package dma_regbank_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_GCTRL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_POLL  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CSEL  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_CCTRL = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CBASE = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_CLEN  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_CSTS  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_CIEN  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_PSEL  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_PCTRL = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_GIEN  = 8'hF4;

  localparam int DONE_BIT = 3;

  typedef struct packed {
    logic ctrl;
    logic base;
    logic len;
    logic sts;
    logic ien;
  } chan_wr_t;
endpackage

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regbank_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int RST_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  chan_wr_t          wr,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] raddr,
  input  logic              glob_rst,
  input  logic              evt,
  output logic [31:0]       rdata,
  output logic              on_o,
  output logic              tx_o,
  output logic [1:0]        weight_o,
  output logic [31:0]       base_o,
  output logic [LEN_W-1:0]  len_o,
  output logic              busy_o,
  output logic              irq_req_o
);
  localparam int CNT_W = $clog2(RST_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [6:1]       sts_q, ien_q;
  logic             start;
  logic [31:0]      rd_val;

  assign start  = (hit & wr.ctrl & wdata[1]) | glob_rst;
  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      on_o     <= 1'b0;
      tx_o     <= 1'b0;
      weight_o <= '0;
      base_o   <= '0;
      len_o    <= '0;
      sts_q    <= '0;
      ien_q    <= '0;
    end else begin
      if (start)       cnt_q <= CNT_W'(RST_CYC);
      else if (busy_o) cnt_q <= cnt_q - 1'b1;

      if (start || busy_o)     on_o <= 1'b0;
      else if (hit && wr.ctrl) on_o <= wdata[0];

      if (hit && wr.ctrl) begin
        tx_o     <= wdata[8];
        weight_o <= wdata[17:16];
      end
      if (hit && wr.base) base_o <= wdata;
      if (hit && wr.len)  len_o  <= wdata[LEN_W-1:0];
      if (hit && wr.ien)  ien_q  <= wdata[6:1];

      if (start || busy_o) begin
        sts_q <= '0;
      end else begin
        sts_q <= sts_q & ~((hit && wr.sts) ? wdata[6:1] : 6'b0);
        if (evt) sts_q[DONE_BIT] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (raddr)
      OFS_CCTRL: rd_val = {14'b0, weight_o, 7'b0, tx_o, 6'b0, busy_o, on_o};
      OFS_CBASE: rd_val = base_o;
      OFS_CLEN:  rd_val = {{(32-LEN_W){1'b0}}, len_o};
      OFS_CSTS:  rd_val = {25'b0, sts_q, 1'b0};
      OFS_CIEN:  rd_val = {25'b0, ien_q, 1'b0};
      default:   rd_val = '0;
    endcase
  end

  assign rdata     = hit ? rd_val : 32'b0;
  assign irq_req_o = |(sts_q & ien_q);

  // R4: a resetting channel is never enabled
  a_r4_busy_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !on_o);
  // R4: reset lasts longer than one cycle
  a_r4_reset_persists: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o);
  // R6: an event on an idle channel sets the done bit
  a_r6_event_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !start && !busy_o) |=> sts_q[DONE_BIT]);
  // R6: write-one clears the done bit when no event competes
  a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && wr.sts && wdata[DONE_BIT] && !evt) |=> !sts_q[DONE_BIT]);
endmodule

// File: rtl/dma_port_slot.sv
module dma_port_slot (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [11:2] wdata,
  output logic [31:0] word_o,
  output logic [3:0]  swap_o,
  output logic        drop_o,
  output logic [1:0]  burst_a_o,
  output logic [1:0]  burst_b_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_o    <= '0;
      drop_o    <= 1'b0;
      burst_a_o <= '0;
      burst_b_o <= '0;
    end else if (wr) begin
      swap_o    <= wdata[11:8];
      drop_o    <= wdata[6];
      burst_a_o <= wdata[5:4];
      burst_b_o <= wdata[3:2];
    end
  end

  assign word_o = {20'b0, swap_o, 1'b0, drop_o, burst_a_o, burst_b_o, 2'b0};

  // R10: fields change only under a write to this port
  a_r10_port_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(word_o));
endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
  import dma_regbank_pkg::*;
#(
  parameter int NUM_CH   = 20,
  parameter int NUM_PORT = 5,
  parameter int LEN_W    = 16,
  parameter int RST_CYC  = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  input  logic [NUM_CH-1:0]         ch_event,
  output logic [NUM_CH-1:0]         ch_on,
  output logic [NUM_CH-1:0]         ch_tx,
  output logic [2*NUM_CH-1:0]       ch_weight,
  output logic [32*NUM_CH-1:0]      ch_base,
  output logic [LEN_W*NUM_CH-1:0]   ch_len,
  output logic [NUM_CH-1:0]         ch_busy,
  output logic                      poll_en,
  output logic                      poll_div4,
  output logic [4*NUM_PORT-1:0]     port_swap,
  output logic [NUM_PORT-1:0]       port_drop,
  output logic [2*NUM_PORT-1:0]     port_burst_a,
  output logic [2*NUM_PORT-1:0]     port_burst_b,
  output logic                      irq
);
  localparam int CH_IDX_W = $clog2(NUM_CH);
  localparam int PT_IDX_W = (NUM_PORT > 1) ? $clog2(NUM_PORT) : 1;

  logic [CH_IDX_W-1:0] csel_q;
  logic                csel_ok_q;
  logic [PT_IDX_W-1:0] psel_q;
  logic                psel_ok_q;
  logic [NUM_CH-1:0]   gien_q;
  logic [NUM_CH-1:0]   irq_req;
  logic [31:0]         ch_rd   [NUM_CH];
  logic [31:0]         port_rd [NUM_PORT];
  logic                glob_rst;
  logic                banked;
  chan_wr_t            cwr;

  assign glob_rst = bus_we && (bus_addr == OFS_GCTRL) && bus_wdata[0];
  assign cwr.ctrl = bus_we && (bus_addr == OFS_CCTRL);
  assign cwr.base = bus_we && (bus_addr == OFS_CBASE);
  assign cwr.len  = bus_we && (bus_addr == OFS_CLEN);
  assign cwr.sts  = bus_we && (bus_addr == OFS_CSTS);
  assign cwr.ien  = bus_we && (bus_addr == OFS_CIEN);
  assign banked   = (bus_addr == OFS_CCTRL) || (bus_addr == OFS_CBASE) ||
                    (bus_addr == OFS_CLEN)  || (bus_addr == OFS_CSTS)  ||
                    (bus_addr == OFS_CIEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q    <= '0;
      csel_ok_q <= 1'b0;
      psel_q    <= '0;
      psel_ok_q <= 1'b0;
      gien_q    <= '0;
      poll_en   <= 1'b0;
      poll_div4 <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_CSEL: begin
          csel_q    <= bus_wdata[CH_IDX_W-1:0];
          csel_ok_q <= (bus_wdata < 32'(NUM_CH));
        end
        OFS_PSEL: begin
          psel_q    <= bus_wdata[PT_IDX_W-1:0];
          psel_ok_q <= (bus_wdata < 32'(NUM_PORT));
        end
        OFS_GIEN: gien_q <= bus_wdata[NUM_CH-1:0];
        OFS_POLL: begin
          poll_en   <= bus_wdata[31];
          poll_div4 <= bus_wdata[6];
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = csel_ok_q && (csel_q == CH_IDX_W'(g));
    dma_chan_slot #(.LEN_W(LEN_W), .RST_CYC(RST_CYC)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .wr        (cwr),
      .wdata     (bus_wdata),
      .raddr     (bus_addr),
      .glob_rst  (glob_rst),
      .evt       (ch_event[g]),
      .rdata     (ch_rd[g]),
      .on_o      (ch_on[g]),
      .tx_o      (ch_tx[g]),
      .weight_o  (ch_weight[2*g +: 2]),
      .base_o    (ch_base[32*g +: 32]),
      .len_o     (ch_len[LEN_W*g +: LEN_W]),
      .busy_o    (ch_busy[g]),
      .irq_req_o (irq_req[g])
    );
  end

  for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
    logic pwr;
    assign pwr = bus_we && (bus_addr == OFS_PCTRL) && psel_ok_q &&
                 (psel_q == PT_IDX_W'(p));
    dma_port_slot u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (pwr),
      .wdata     (bus_wdata[11:2]),
      .word_o    (port_rd[p]),
      .swap_o    (port_swap[4*p +: 4]),
      .drop_o    (port_drop[p]),
      .burst_a_o (port_burst_a[2*p +: 2]),
      .burst_b_o (port_burst_b[2*p +: 2])
    );
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_GCTRL: bus_rdata[0] = |ch_busy;
      OFS_POLL: begin
        bus_rdata[31] = poll_en;
        bus_rdata[6]  = poll_div4;
      end
      OFS_GIEN: bus_rdata[NUM_CH-1:0] = gien_q;
      OFS_PCTRL: begin
        for (int i = 0; i < NUM_PORT; i++)
          if (psel_ok_q && (psel_q == PT_IDX_W'(i))) bus_rdata = port_rd[i];
      end
      default: begin
        for (int i = 0; i < NUM_CH; i++) bus_rdata = bus_rdata | ch_rd[i];
      end
    endcase
  end

  assign irq = |(irq_req & gien_q);

  // R7: interrupt only passes through a set global mask bit
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|gien_q));
  // R11: out-of-range channel select reads zero on banked offsets
  a_r11_bad_sel_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!csel_ok_q && !bus_we && banked) |-> (bus_rdata == 32'b0));
  // R11: out-of-range channel select leaves channel enables alone
  a_r11_bad_sel_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!csel_ok_q && cwr.ctrl) |=> $stable(ch_on));
endmodule

// File: tb/test_dma_regbank.sv
module test_dma_regbank;
  localparam int NUM_CH = 20, NUM_PORT = 5, LEN_W = 16, RST_CYC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NUM_CH-1:0] ch_event = '0, ch_on, ch_tx, ch_busy;
  logic [2*NUM_CH-1:0] ch_weight;
  logic [32*NUM_CH-1:0] ch_base;
  logic [LEN_W*NUM_CH-1:0] ch_len;
  logic poll_en, poll_div4, irq;
  logic [4*NUM_PORT-1:0] port_swap;
  logic [NUM_PORT-1:0] port_drop;
  logic [2*NUM_PORT-1:0] port_burst_a, port_burst_b;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_regbank #(.NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .LEN_W(LEN_W),
                .RST_CYC(RST_CYC)) i_dma_regbank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_event(ch_event),
    .ch_on(ch_on), .ch_tx(ch_tx), .ch_weight(ch_weight), .ch_base(ch_base),
    .ch_len(ch_len), .ch_busy(ch_busy), .poll_en(poll_en),
    .poll_div4(poll_div4), .port_swap(port_swap), .port_drop(port_drop),
    .port_burst_a(port_burst_a), .port_burst_b(port_burst_b), .irq(irq));

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    bus_we = 1'b0; bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // {req, we, addr, wdata, expected read}
  localparam int NV = 27;
  localparam logic [76:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h18, 32'h2,          32'h0},        // R2 select ch2
    {4'd3,  1'b1, 8'h1C, 32'h0003_0101,  32'h0},        // R3 weight 3, tx, on
    {4'd5,  1'b1, 8'h20, 32'hDEAD_BEE0,  32'h0},        // R5
    {4'd5,  1'b1, 8'h24, 32'hFFFF_0040,  32'h0},        // R5 count truncated
    {4'd3,  1'b0, 8'h1C, 32'h0,          32'h0003_0101},// R3
    {4'd5,  1'b0, 8'h20, 32'h0,          32'hDEAD_BEE0},// R5
    {4'd5,  1'b0, 8'h24, 32'h0,          32'h0000_0040},// R5
    {4'd2,  1'b1, 8'h18, 32'h7,          32'h0},        // R2 select ch7
    {4'd2,  1'b0, 8'h1C, 32'h0,          32'h0},        // R2 ch7 untouched
    {4'd2,  1'b0, 8'h20, 32'h0,          32'h0},        // R2
    {4'd3,  1'b1, 8'h1C, 32'h0001_0001,  32'h0},        // R3
    {4'd3,  1'b0, 8'h1C, 32'h0,          32'h0001_0001},// R3
    {4'd2,  1'b1, 8'h18, 32'h2,          32'h0},        // R2 back to ch2
    {4'd2,  1'b0, 8'h1C, 32'h0,          32'h0003_0101},// R2
    {4'd11, 1'b0, 8'h18, 32'h0,          32'h0},        // R11 select reads 0
    {4'd9,  1'b1, 8'h14, 32'hFFFF_FFFF,  32'h0},        // R9
    {4'd9,  1'b0, 8'h14, 32'h0,          32'h8000_0040},// R9
    {4'd10, 1'b1, 8'h40, 32'h1,          32'h0},        // R10 port 1
    {4'd10, 1'b1, 8'h44, 32'hFFFF_FFFF,  32'h0},        // R10
    {4'd10, 1'b0, 8'h44, 32'h0,          32'h0000_0F7C},// R10
    {4'd10, 1'b1, 8'h40, 32'h0,          32'h0},        // R10 port 0
    {4'd10, 1'b0, 8'h44, 32'h0,          32'h0},        // R10 isolation
    {4'd11, 1'b0, 8'h40, 32'h0,          32'h0},        // R11
    {4'd11, 1'b0, 8'h30, 32'h0,          32'h0},        // R11 unmapped
    {4'd7,  1'b1, 8'h2C, 32'hFFFF_FFFF,  32'h0},        // R7 enables
    {4'd7,  1'b0, 8'h2C, 32'h0,          32'h0000_007E},// R7
    {4'd7,  1'b1, 8'hF4, 32'hFFFF_FFFF,  32'h0}         // R7 global mask
  };

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 ch_on", 32'(ch_on), 32'h0);
    chk("R1 ch_busy", 32'(ch_busy), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 poll", {30'b0, poll_en, poll_div4}, 32'h0);
    rd("R1 gien", 8'hF4, 32'h0);
    rd("R1 csel invalid", 8'h1C, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [76:0] v;
      v = VEC[i];
      if (v[72]) wr(v[71:64], v[63:32]);
      else rd($sformatf("R%0d vec%0d", v[76:73], i), v[71:64], v[31:0]);
    end
    rd("R7 gien readback", 8'hF4, 32'h000F_FFFF);
    wr(8'hF4, 32'h0);

    chk("R3 ch_on", 32'(ch_on), 32'h0000_0084);
    chk("R3 ch_tx", 32'(ch_tx), 32'h0000_0004);
    chk("R3 ch_weight", 32'(ch_weight[5:4]), 32'h3);
    chk("R5 ch_base", ch_base[32*2 +: 32], 32'hDEAD_BEE0);
    chk("R5 ch_len", 32'(ch_len[LEN_W*2 +: LEN_W]), 32'h40);
    chk("R9 poll pins", {30'b0, poll_en, poll_div4}, 32'h3);
    chk("R10 port1 pins", {24'b0, port_swap[7:4], port_drop[1],
        port_burst_a[3:2], port_burst_b[3]}, 32'hFF);
    chk("R10 port0 pins", 32'(port_swap[3:0]), 32'h0);

    // R4 channel reset on ch2
    wr(8'h18, 32'h2);
    wr(8'h1C, 32'h2);
    for (int k = 0; k < RST_CYC; k++) begin
      rd($sformatf("R4 busy cycle %0d", k), 8'h1C, 32'h2);
      if (k == 1) wr(8'h1C, 32'h1);
      else tick();
    end
    rd("R4 reset done", 8'h1C, 32'h0);
    chk("R4 on cleared", 32'(ch_on[2]), 32'h0);
    rd("R4 base kept", 8'h20, 32'hDEAD_BEE0);
    rd("R4 len kept", 8'h24, 32'h40);

    // R6 / R7 events and interrupt
    wr(8'h18, 32'h5);
    wr(8'h2C, 32'h08);
    wr(8'hF4, 32'h20);
    chk("R7 irq idle", 32'(irq), 32'h0);
    ch_event[5] = 1'b1; ch_event[6] = 1'b1;
    tick();
    ch_event = '0;
    rd("R6 status set", 8'h28, 32'h08);
    chk("R7 irq on", 32'(irq), 32'h1);
    wr(8'hF4, 32'h0);
    chk("R7 irq masked", 32'(irq), 32'h0);
    wr(8'hF4, 32'h40);
    chk("R7 ch6 enable off", 32'(irq), 32'h0);
    wr(8'h18, 32'h6);
    rd("R6 ch6 status", 8'h28, 32'h08);
    wr(8'h18, 32'h5);
    wr(8'hF4, 32'h20);
    wr(8'h28, 32'h7E);
    rd("R6 w1c", 8'h28, 32'h0);
    chk("R7 irq after clear", 32'(irq), 32'h0);

    // R8 engine-wide reset
    wr(8'h10, 32'h1);
    rd("R8 busy", 8'h10, 32'h1);
    chk("R8 all busy", 32'(ch_busy), 32'h000F_FFFF);
    chk("R8 all off", 32'(ch_on), 32'h0);
    repeat (RST_CYC) tick();
    rd("R8 done", 8'h10, 32'h0);
    wr(8'h18, 32'h6);
    rd("R8 status cleared", 8'h28, 32'h0);

    // R11 out-of-range select
    wr(8'h18, 32'd20);
    wr(8'h1C, 32'h101);
    chk("R11 no enable", 32'(ch_on), 32'h0);
    rd("R11 banked read", 8'h1C, 32'h0);
    wr(8'h18, 32'h0000_0104);
    rd("R11 wide select", 8'h20, 32'h0);
    wr(8'h18, 32'h0);
    rd("R11 ch0 unchanged", 8'h1C, 32'h0);
    wr(8'h40, 32'd9);
    wr(8'h44, 32'hF00);
    chk("R11 port untouched", 32'(port_swap), 32'h0000_00F0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule